// File: doc/BRIEF.md
# SD Host Card Interrupt Register Unit

This unit sits inside an SD/SDIO host controller and turns the interrupt line of the attached card into a system interrupt. It watches one interrupt line per card port and uses a port-select input to pick which line counts. It holds three 16-bit registers, written and read through a simple register port: a control register, a status register and a mask register.

When the enable bit of the control register is set, the selected line is copied into status bit 0 each time an evaluation event happens. Status bits whose mask bit is clear are pending. When the pending set goes from empty to non-empty, the unit emits a one-cycle pulse on two outputs at once. One output is the controller interrupt and the other is the data-line-1 interrupt. Software clears status bits by writing zeros to them, because a write is ANDed into the register.

All state changes on the rising clock edge. The pulse outputs are registered, so they are high during the cycle that follows the edge on which the event was sampled.

Top module: `sdh_card_irq`

## Requirements
- R1: The control register is at byte offset 0x34 and resets to 0. A write keeps only the bits set in 0x0305 and forces every other bit to 0. Bit 0 is the capture enable.
- R2: The mask register is at offset 0x38 and resets to 0xC007. A write keeps only the bits set in 0xC007. A mask bit of 1 hides the matching status bit.
- R3: The status register is at offset 0x36 and resets to 0. A write stores the AND of the old value and the written value. Any offset other than 0x34, 0x36 or 0x38 reads as 0.
- R4: While control bit 0 is 0, changes on the card lines leave the status register unchanged and produce no pulse.
- R5: While control bit 0 is 1, each evaluation event sets status bit 0 to the current level of the line of the selected port.
- R6: Only three things are evaluation events: a write to control, a write to mask, and a change of the selected port's line compared with that port's level on the previous edge. A change of the port select alone is not an event. A write to status is not an event.
- R7: Both outputs pulse when an evaluation event, with capture enabled, takes the pending bits (status AND NOT mask) from all zero to non-zero. The old pending value uses the mask written in the same cycle.
- R8: A pulse lasts exactly one cycle. While pending bits stay non-zero, no further pulse occurs. A mask write that only unmasks an already set status bit does not pulse.
- R9: Register writes take effect at the edge on which they are sampled. A pulse is high during the cycle right after that edge. Register reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| card_irq | input | 2 | Interrupt line of each card port |
| port_sel | input | 1 | Selected card port |
| host_irq_pulse | output | 1 | Controller interrupt pulse |
| dat1_irq_pulse | output | 1 | Data-line-1 interrupt pulse |

## Verification
The hardest state to reach is a status bit that has been cleared by software while the card line is still high. In that state only a later control or mask write brings the bit back. The stimulus clears status bit 0 by writing 0xFFFE while the line stays asserted. It then rewrites the mask and checks that status comes back and that one pulse follows. The stimulus also switches the port select to a line that is already high, which must not count as an event. It also unmasks a bit that is already set, which must not pulse. A behavioural model in the bench is compared with the read data and both pulses on every clock.

// File: rtl/sdh_cirq_pkg.sv
// Package: shared constants of the card interrupt register unit.
// Assumes byte offsets within a 9-bit host register window.
package sdh_cirq_pkg;
    localparam int          CIRQ_REG_W     = 16;
    localparam int          CIRQ_CTL_OFS   = 'h34;
    localparam int          CIRQ_STAT_OFS  = 'h36;
    localparam int          CIRQ_MASK_OFS  = 'h38;
    localparam logic [15:0] CIRQ_CTL_WMASK = 16'h0305;
    localparam logic [15:0] CIRQ_MSK_WMASK = 16'hC007;
    localparam logic [15:0] CIRQ_MSK_RST   = 16'hC007;
endpackage

// File: rtl/cirq_regs.sv
// Module: control and mask registers with their write decode.
// Assumes a single write strobe per cycle.
// Also provides the next-state values (used by the evaluation in the same
// cycle), a config event flag and a status write flag.
module cirq_regs #(
    parameter int               ADDR_W   = 9,
    parameter int               REG_W    = 16,
    parameter int               CTL_OFS  = 'h34,
    parameter int               STAT_OFS = 'h36,
    parameter int               MASK_OFS = 'h38,
    parameter logic [REG_W-1:0] CTL_WM   = 16'h0305,
    parameter logic [REG_W-1:0] MSK_WM   = 16'hC007,
    parameter logic [REG_W-1:0] MSK_RST  = 16'hC007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  ctl_q,
    output logic [REG_W-1:0]  mask_q,
    output logic [REG_W-1:0]  ctl_n,
    output logic [REG_W-1:0]  mask_n,
    output logic              cfg_event,
    output logic              stat_wr
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

    logic ctl_wr, mask_wr;

    // Decode the write strobe into one hit per register.
    always_comb begin
        ctl_wr    = wen && (addr == A_CTL);
        mask_wr   = wen && (addr == A_MASK);
        stat_wr   = wen && (addr == A_STAT);
        cfg_event = ctl_wr || mask_wr;
    end

    // Next-state values, with the writable-bit masks applied.
    always_comb begin
        ctl_n  = ctl_wr  ? (wdata & CTL_WM) : ctl_q;
        mask_n = mask_wr ? (wdata & MSK_WM) : mask_q;
    end

    // Register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            mask_q <= MSK_RST;
        end else begin
            ctl_q  <= ctl_n;
            mask_q <= mask_n;
        end
    end

    a_r1_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_q == ($past(wdata) & CTL_WM)));
    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == ($past(wdata) & MSK_WM)));
endmodule

// File: rtl/cirq_line.sv
// Module: samples the card interrupt lines and reports a change on the
// selected port. Assumes the lines are already synchronous to clk.
module cirq_line #(
    parameter int NUM_PORTS = 2,
    parameter int SEL_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] card_irq,
    input  logic [SEL_W-1:0]     port_sel,
    output logic                 line_sel,
    output logic                 line_event
);
    logic [NUM_PORTS-1:0] card_q;

    // Select the line of the chosen port and compare it with its last sample.
    always_comb begin
        line_sel   = card_irq[port_sel];
        line_event = card_irq[port_sel] != card_q[port_sel];
    end

    // Keep the previous level of every port.
    always_ff @(posedge clk) begin
        if (!rst_n) card_q <= '0;
        else        card_q <= card_irq;
    end
endmodule

// File: rtl/cirq_status.sv
// Module: the status register, the pending evaluation and the pulse
// generator. Assumes the next-state control and mask values come from the
// register block.
module cirq_status #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             cap_en,
    input  logic [REG_W-1:0] mask_n,
    input  logic             eval,
    input  logic             line_sel,
    output logic [REG_W-1:0] status_q,
    output logic             pulse_q
);
    logic [REG_W-1:0] status_and, status_n, old_pend, new_pend;
    logic             fire;

    // Apply the AND write first, then the line capture on an event.
    always_comb begin
        status_and = stat_wr ? (status_q & wdata) : status_q;
        status_n   = status_and;
        if (eval && cap_en) status_n[0] = line_sel;
        old_pend   = status_and & ~mask_n;
        new_pend   = status_n & ~mask_n;
        fire       = eval && cap_en && (old_pend == '0) && (new_pend != '0);
    end

    // Status storage and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            pulse_q  <= 1'b0;
        end else begin
            status_q <= status_n;
            pulse_q  <= fire;
        end
    end

    a_r4_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !stat_wr) |=> $stable(status_q));
    a_r6_no_event_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval && !stat_wr) |=> $stable(status_q));
    a_r7_pulse_has_status: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> status_q[0]);
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/sdh_card_irq.sv
// Module: top of the card interrupt register unit. Connects the register
// block, the line sampler and the status/pulse logic, and drives the
// combinational read mux. Assumes one register access per cycle.
module sdh_card_irq
    import sdh_cirq_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 9,
    parameter int SEL_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wen,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [CIRQ_REG_W-1:0] reg_wdata,
    output logic [CIRQ_REG_W-1:0] reg_rdata,
    input  logic [NUM_PORTS-1:0]  card_irq,
    input  logic [SEL_W-1:0]      port_sel,
    output logic                  host_irq_pulse,
    output logic                  dat1_irq_pulse
);
    localparam int REG_W = CIRQ_REG_W;

    logic [REG_W-1:0] ctl_q, mask_q, ctl_n, mask_n, status_q;
    logic             cfg_event, stat_wr, line_sel, line_event, pulse_q;

    cirq_regs #(
        .ADDR_W(ADDR_W), .REG_W(REG_W),
        .CTL_OFS(CIRQ_CTL_OFS), .STAT_OFS(CIRQ_STAT_OFS), .MASK_OFS(CIRQ_MASK_OFS),
        .CTL_WM(CIRQ_CTL_WMASK), .MSK_WM(CIRQ_MSK_WMASK), .MSK_RST(CIRQ_MSK_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
        .ctl_q(ctl_q), .mask_q(mask_q), .ctl_n(ctl_n), .mask_n(mask_n),
        .cfg_event(cfg_event), .stat_wr(stat_wr)
    );

    cirq_line #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_line (
        .clk(clk), .rst_n(rst_n), .card_irq(card_irq), .port_sel(port_sel),
        .line_sel(line_sel), .line_event(line_event)
    );

    cirq_status #(.REG_W(REG_W)) u_status (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wdata(reg_wdata),
        .cap_en(ctl_n[0]), .mask_n(mask_n), .eval(cfg_event || line_event),
        .line_sel(line_sel), .status_q(status_q), .pulse_q(pulse_q)
    );

    // Read mux: unused offsets return zero.
    always_comb begin
        if (reg_addr == ADDR_W'(CIRQ_CTL_OFS))       reg_rdata = ctl_q;
        else if (reg_addr == ADDR_W'(CIRQ_STAT_OFS)) reg_rdata = status_q;
        else if (reg_addr == ADDR_W'(CIRQ_MASK_OFS)) reg_rdata = mask_q;
        else                                         reg_rdata = '0;
    end

    // Both interrupt outputs come from the same registered pulse.
    always_comb begin
        host_irq_pulse = pulse_q;
        dat1_irq_pulse = pulse_q;
    end
endmodule

// File: tb/sdh_card_irq_bench.sv
`timescale 1ns/1ps
module sdh_card_irq_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wen = 0;
    logic [8:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic [1:0]  card_irq = 0;
    logic [0:0]  port_sel = 0;
    logic        host_irq_pulse, dat1_irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_ctl = 0, m_stat = 0, m_mask = 'hC007, m_pulse = 0;
    int m_prev[2] = '{0, 0};

    always #5 clk = ~clk;

    sdh_card_irq u_sdh_card_irq (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_irq(card_irq),
        .port_sel(port_sel), .host_irq_pulse(host_irq_pulse),
        .dat1_irq_pulse(dat1_irq_pulse)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: update at each edge, compare 1 ns later.
    always @(posedge clk) begin
        int trig, line, oldp, newp, exp_rd;
        string tag;
        if (!rst_n) begin
            m_ctl = 0; m_stat = 0; m_mask = 'hC007; m_pulse = 0;
            m_prev[0] = 0; m_prev[1] = 0;
        end else begin
            trig = 0;
            if (reg_wen) begin
                if (reg_addr == 9'h34) begin m_ctl = reg_wdata & 'h0305; trig = 1; end
                else if (reg_addr == 9'h38) begin m_mask = reg_wdata & 'hC007; trig = 1; end
                else if (reg_addr == 9'h36) m_stat = m_stat & reg_wdata;
            end
            line = card_irq[port_sel];
            if (line != m_prev[port_sel]) trig = 1;
            oldp = m_stat & ~m_mask & 'hFFFF;
            if (trig && m_ctl[0]) m_stat = (m_stat & 'hFFFE) | line;
            newp = m_stat & ~m_mask & 'hFFFF;
            m_pulse = (trig && m_ctl[0] && oldp == 0 && newp != 0) ? 1 : 0;
            m_prev[0] = card_irq[0]; m_prev[1] = card_irq[1];
        end
        #1;
        if (!done) begin
            case (reg_addr)
                9'h34: begin exp_rd = m_ctl;  tag = "R1 ctl read"; end
                9'h36: begin exp_rd = m_stat; tag = "R3 R5 R6 status read"; end
                9'h38: begin exp_rd = m_mask; tag = "R2 mask read"; end
                default: begin exp_rd = 0;    tag = "R3 unused offset"; end
            endcase
            check(tag, reg_rdata, exp_rd);
            check("R7 R8 R9 host pulse", host_irq_pulse, m_pulse);
            check("R7 dat1 pulse", dat1_irq_pulse, m_pulse);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); reg_wen = 1; reg_addr = 9'(a); reg_wdata = 16'(d);
        @(negedge clk); reg_wen = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setcard(int v, int s);
        @(negedge clk); card_irq = 2'(v); port_sel = 1'(s);
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk); reg_addr = 9'(a); #1;
        check(tag, reg_rdata, exp);
    endtask

    // Pulse watcher: counts pulses for directed checks.
    int npulse = 0;
    always @(posedge clk) begin
        #2; if (host_irq_pulse) npulse++;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        // R1 R2 R3 reset values
        rd('h34, 0, "R1 ctl reset");
        rd('h38, 'hC007, "R2 mask reset");
        rd('h36, 0, "R3 status reset");
        wr('h34, 'hFFFE);
        rd('h34, 'h0304, "R1 ctl writable bits");
        wr('h38, 'hFFFF);
        rd('h38, 'hC007, "R2 mask writable bits");
        wr('h38, 0);
        // R4: disabled capture ignores the card line
        npulse = 0;
        setcard(1, 0); idle(3);
        rd('h36, 0, "R4 status frozen while disabled");
        check("R4 no pulse while disabled", npulse, 0);
        // R5 R7: enabling captures the high line and pulses once
        npulse = 0;
        wr('h34, 1); idle(4);
        rd('h36, 1, "R5 status follows line");
        check("R7 R8 one pulse on enable", npulse, 1);
        // R6: unselected port toggles do nothing
        setcard(3, 0); setcard(1, 0); idle(2);
        // R3 R6: clear with line still high, stays clear without an event
        npulse = 0;
        wr('h36, 'hFFFE); idle(3);
        rd('h36, 0, "R6 cleared status not refreshed");
        wr('h38, 0); idle(2);
        rd('h36, 1, "R6 mask write refreshes status");
        check("R7 pulse after refresh", npulse, 1);
        // R8: mask then unmask a set bit, no pulse
        npulse = 0;
        wr('h38, 1); wr('h38, 0); idle(2);
        check("R8 unmask gives no pulse", npulse, 0);
        // R5: line drop clears the bit
        setcard(0, 0); idle(2);
        rd('h36, 0, "R5 line low clears bit");
        // R6: port select switch alone is not an event
        setcard(2, 0); idle(1); npulse = 0;
        setcard(2, 1); idle(3);
        rd('h36, 0, "R6 select change not an event");
        setcard(0, 1); setcard(2, 1); idle(3);
        rd('h36, 1, "R5 selected port captured");
        check("R7 pulse from port 1", npulse, 1);
        // R4: disable again and toggle
        wr('h34, 'h0304); npulse = 0;
        setcard(0, 1); setcard(2, 1); setcard(0, 1); idle(3);
        rd('h36, 1, "R4 status held when disabled");
        check("R4 no pulse disabled", npulse, 0);
        rd('h3A, 0, "R3 unused offset");
        // Mixed patterns compared by the model on every clock.
        wr('h34, 1);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            card_irq = 2'((k * 7 + k / 3) % 4);
            port_sel = 1'((k / 5) % 2);
            reg_addr = 9'h36;
            if (k % 11 == 0) begin reg_wen = 1; reg_addr = 9'h36; reg_wdata = 16'hFFFE; end
            else if (k % 13 == 0) begin reg_wen = 1; reg_addr = 9'h38; reg_wdata = 16'(k % 2); end
            else if (k % 17 == 0) begin reg_wen = 1; reg_addr = 9'h34; reg_wdata = 16'((k / 17) % 2); end
            else reg_wen = 0;
        end
        @(negedge clk); reg_wen = 0;
        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule